// File: doc/BRIEF.md
# Page-Mode Multiplexed-Address DRAM Controller

This block connects a simple synchronous request port to an asynchronous-style DRAM device. The device has a shared row/column address bus, one bidirectional data bus and four active-low strobes. For each request, the word address is split into a row half and a column half. The row is presented first and latched when the row strobe falls. The column is presented next and latched when the column strobe falls. Every minimum device timing is a parameter counted in controller clock cycles, and the controller waits out each one before it moves a strobe.

Each request carries a hint that asks the controller to keep the row open. When the hint is set, the row strobe stays low after the access. A following request to the same row then costs only a column strobe pulse. A request to another row first closes the open row, waits out the precharge interval and then opens the new row. A refresh scheduler raises a request at a fixed interval. The controller serves it with a row-strobe-only cycle on the next row in sequence, so every row is refreshed within the retention period. A pending refresh takes priority over new requests and also closes any row that is being held open.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, all four strobes (row, column, write, output enable) are high, `req_ready` is 1, `rd_valid` is 0 and the data bus is released (high impedance).
- R2: The request address splits into row = `req_addr[17:9]` and column = `req_addr[8:0]`. The row is stable on `dram_addr` when `dram_ras_n` falls, and the column is stable on `dram_addr` when `dram_cas_n` falls.
- R3: A write is an early-write cycle. `dram_we_n` goes low at least one cycle before `dram_cas_n` falls, `dram_oe_n` stays high, and the controller drives `req_wdata` on `dram_dq`.
- R4: For a read, `dram_we_n` is high, `dram_oe_n` is low and the bus is released. The bus value at the end of the column pulse appears on `rd_data` with a one-cycle `rd_valid` pulse, and read results come back in request order.
- R5: If a request is accepted while its row is held open (hint set on the previous access) and it targets the same row, only `dram_cas_n` toggles, and `dram_ras_n` stays low.
- R6: A request to a row other than the open one raises `dram_ras_n`. The row strobe stays high for at least T_RP cycles before the new row is opened.
- R7: Successive falling edges of `dram_ras_n` are at least T_RC cycles apart.
- R8: Successive falling edges of `dram_cas_n` are at least T_PC cycles apart, and each column pulse is low for at least T_CAC cycles.
- R9: The first column strobe of a row falls at least T_RAC − T_CAC cycles after the row strobe falls, so read data is sampled no sooner than T_RAC cycles after the row opens.
- R10: Every REF_PERIOD cycles, a refresh is issued. A refresh is a row-strobe-only cycle (column strobe stays high) with the row strobe low for at least T_RAC cycles. Successive refresh cycles address rows 0, 1, 2, … in order, wrapping modulo 512.
- R11: A pending refresh closes a held-open row and blocks new requests (`req_ready` low) until the refresh row cycle has started.
- R12: If the hint is clear, `dram_ras_n` rises in the same cycle that `dram_cas_n` rises at the end of the access.
- R13: A request is accepted only when `req_valid` and `req_ready` are both 1, and `req_ready` is never 1 while `dram_cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in upper half |
| req_wdata | input | 8 | Write data |
| req_hold | input | 1 | Keep the row open after this access |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq | inout | 8 | Bidirectional data bus |

## Verification
The bound checker checks, on every cycle, the rules that can be seen from the strobes alone. These are the strobe spacings for row cycle, page cycle, precharge and column pulse width; address stability at each falling strobe; write enable settling before the column strobe; exclusion of write enable and output enable; bus release during reads; the column strobe only while the row strobe is low; and the shape of the ready and valid signals. Other behaviour depends on request content and device state, so only the bench scenarios can show it. This covers read data matching earlier writes through a behavioural device model; the row staying open across same-row hits and closing on a miss or when the hint is clear; refresh rows advancing in order; and a refresh pre-empting a held-open row.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,    // row closed, waiting for work
      ST_ROWSET,  // row address on bus, waiting for row-cycle and precharge minimums
      ST_RCD,     // row strobe low, column address and direction being set up
      ST_COLSET,  // open row hit, waiting for page-cycle minimum
      ST_CAS,     // column strobe low
      ST_OPEN,    // row held open between accesses
      ST_REF      // row-only refresh cycle
   } seq_state_e;
endpackage

// File: rtl/fpm_cyc_timer.sv
module fpm_cyc_timer #(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic             done
);
   logic [WIDTH-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               remain <= '0;
      else if (load)            remain <= load_val;
      else if (remain != '0)    remain <= remain - 1'b1;
   end

   assign done = (remain == '0);
endmodule

// File: rtl/fpm_refresh_sched.sv
module fpm_refresh_sched #(
   parameter int PERIOD = 3125,
   parameter int ROW_W  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   output logic             pending,
   output logic [ROW_W-1:0] row
);
   localparam int CW = $clog2(PERIOD);

   logic [CW-1:0] tick_cnt;
   logic          tick;

   assign tick = (tick_cnt == CW'(PERIOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt <= '0;
         pending  <= 1'b0;
         row      <= '0;
      end else begin
         tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
         if (tick)      pending <= 1'b1;
         else if (ack)  pending <= 1'b0;
         if (ack)       row <= row + 1'b1;
      end
   end
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
   import fpm_dram_pkg::*;
#(
   parameter int MUX_W  = 9,
   parameter int DATA_W = 8,
   parameter int T_RAC  = 12,
   parameter int T_RC   = 22,
   parameter int T_CAC  = 3,
   parameter int T_PC   = 7,
   parameter int T_RP   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [MUX_W-1:0]  req_row,
   input  logic [MUX_W-1:0]  req_col,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_hold,
   output logic              req_ready,
   input  logic              ref_pend,
   input  logic [MUX_W-1:0]  ref_row,
   output logic              ref_ack,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_drive,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [MUX_W-1:0]  addr
);
   localparam int T_RCD = T_RAC - T_CAC;
   localparam int TMR_W = $clog2(T_RC + T_RP + T_RAC + T_PC + 1);

   seq_state_e        state;
   logic [MUX_W-1:0]  row_q, col_q, open_row;
   logic [DATA_W-1:0] wd_q;
   logic              wr_q, hold_q, pend_q, is_ref;

   logic rc_done, pc_done, pre_done, wait_done;
   logic accept, same_row, ras_fall, ras_rise, cas_fall, cas_end, ref_end;
   logic wait_load;
   logic [TMR_W-1:0] wait_val;

   always_comb begin
      req_ready = !ref_pend && ((state == ST_IDLE && !pend_q) || state == ST_OPEN);
      accept    = req_valid && req_ready;
      same_row  = (req_row == open_row);
      ras_fall  = (state == ST_ROWSET) && rc_done && pre_done;
      cas_fall  = ((state == ST_RCD) && wait_done) || ((state == ST_COLSET) && pc_done);
      cas_end   = (state == ST_CAS) && wait_done;
      ref_end   = (state == ST_REF) && wait_done;
      ras_rise  = (cas_end && !hold_q) || ref_end ||
                  ((state == ST_OPEN) && (ref_pend || (accept && !same_row)));
      wait_load = ras_fall || cas_fall;
      if (ras_fall) wait_val = is_ref ? TMR_W'(T_RAC - 1) : TMR_W'(T_RCD - 1);
      else          wait_val = TMR_W'(T_CAC - 1);
      ref_ack   = ras_fall && is_ref;
   end

   fpm_cyc_timer #(.WIDTH(TMR_W)) u_rc_tmr (
      .clk(clk), .rst_n(rst_n), .load(ras_fall),
      .load_val(TMR_W'(T_RC - 1)), .done(rc_done));

   fpm_cyc_timer #(.WIDTH(TMR_W)) u_pc_tmr (
      .clk(clk), .rst_n(rst_n), .load(cas_fall),
      .load_val(TMR_W'(T_PC - 1)), .done(pc_done));

   fpm_cyc_timer #(.WIDTH(TMR_W)) u_pre_tmr (
      .clk(clk), .rst_n(rst_n), .load(ras_rise),
      .load_val(TMR_W'(T_RP - 1)), .done(pre_done));

   fpm_cyc_timer #(.WIDTH(TMR_W)) u_wait_tmr (
      .clk(clk), .rst_n(rst_n), .load(wait_load),
      .load_val(wait_val), .done(wait_done));

   assign dq_out = wd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ras_n    <= 1'b1;
         cas_n    <= 1'b1;
         we_n     <= 1'b1;
         oe_n     <= 1'b1;
         addr     <= '0;
         dq_drive <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         row_q    <= '0;
         col_q    <= '0;
         open_row <= '0;
         wd_q     <= '0;
         wr_q     <= 1'b0;
         hold_q   <= 1'b0;
         pend_q   <= 1'b0;
         is_ref   <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         if (accept) begin
            row_q  <= req_row;
            col_q  <= req_col;
            wd_q   <= req_wdata;
            wr_q   <= req_write;
            hold_q <= req_hold;
         end
         unique case (state)
            ST_IDLE: begin
               if (pend_q) begin
                  pend_q <= 1'b0;
                  state  <= ST_ROWSET;
               end else if (ref_pend) begin
                  addr   <= ref_row;
                  is_ref <= 1'b1;
                  state  <= ST_ROWSET;
               end else if (accept) begin
                  addr   <= req_row;
                  is_ref <= 1'b0;
                  state  <= ST_ROWSET;
               end
            end
            ST_ROWSET: begin
               if (ras_fall) begin
                  ras_n <= 1'b0;
                  if (!is_ref) open_row <= row_q;
                  state <= is_ref ? ST_REF : ST_RCD;
               end
            end
            ST_RCD: begin
               addr     <= col_q;
               we_n     <= !wr_q;
               oe_n     <= wr_q;
               dq_drive <= wr_q;
               if (cas_fall) begin
                  cas_n <= 1'b0;
                  state <= ST_CAS;
               end
            end
            ST_COLSET: begin
               if (cas_fall) begin
                  cas_n <= 1'b0;
                  state <= ST_CAS;
               end
            end
            ST_CAS: begin
               if (cas_end) begin
                  cas_n    <= 1'b1;
                  we_n     <= 1'b1;
                  oe_n     <= 1'b1;
                  dq_drive <= 1'b0;
                  if (!wr_q) begin
                     rd_valid <= 1'b1;
                     rd_data  <= dq_in;
                  end
                  if (hold_q) begin
                     state <= ST_OPEN;
                  end else begin
                     ras_n <= 1'b1;
                     state <= ST_IDLE;
                  end
               end
            end
            ST_OPEN: begin
               if (ref_pend) begin
                  ras_n <= 1'b1;
                  state <= ST_IDLE;
               end else if (accept) begin
                  is_ref <= 1'b0;
                  if (same_row) begin
                     addr     <= req_col;
                     we_n     <= !req_write;
                     oe_n     <= req_write;
                     dq_drive <= req_write;
                     state    <= ST_COLSET;
                  end else begin
                     addr   <= req_row;
                     pend_q <= 1'b1;
                     ras_n  <= 1'b1;
                     state  <= ST_IDLE;
                  end
               end
            end
            ST_REF: begin
               if (ref_end) begin
                  ras_n <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
   parameter int ROW_W      = 9,
   parameter int COL_W      = 9,
   parameter int DATA_W     = 8,
   parameter int T_RAC      = 12,
   parameter int T_RC       = 22,
   parameter int T_CAC      = 3,
   parameter int T_PC       = 7,
   parameter int T_RP       = 10,
   parameter int REF_PERIOD = 3125,
   localparam int ADDR_W    = ROW_W + COL_W,
   localparam int MUX_W     = (ROW_W >= COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_hold,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [MUX_W-1:0]  dram_addr,
   inout  wire  [DATA_W-1:0] dram_dq
);
   logic [MUX_W-1:0]  req_row_m, req_col_m, ref_row_m;
   logic [ROW_W-1:0]  ref_row;
   logic              ref_pend, ref_ack;
   logic [DATA_W-1:0] dq_out;
   logic              dq_drive;

   generate
      if (ROW_W >= COL_W) begin : g_row_wide
         assign req_row_m = req_addr[ADDR_W-1:COL_W];
         assign req_col_m = MUX_W'(req_addr[COL_W-1:0]);
         assign ref_row_m = ref_row;
      end else begin : g_col_wide
         assign req_row_m = MUX_W'(req_addr[ADDR_W-1:COL_W]);
         assign req_col_m = req_addr[COL_W-1:0];
         assign ref_row_m = MUX_W'(ref_row);
      end
   endgenerate

   fpm_refresh_sched #(.PERIOD(REF_PERIOD), .ROW_W(ROW_W)) u_ref (
      .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pend), .row(ref_row));

   fpm_seq #(
      .MUX_W(MUX_W), .DATA_W(DATA_W), .T_RAC(T_RAC), .T_RC(T_RC),
      .T_CAC(T_CAC), .T_PC(T_PC), .T_RP(T_RP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_row(req_row_m), .req_col(req_col_m),
      .req_wdata(req_wdata), .req_hold(req_hold), .req_ready(req_ready),
      .ref_pend(ref_pend), .ref_row(ref_row_m), .ref_ack(ref_ack),
      .dq_in(dram_dq), .dq_out(dq_out), .dq_drive(dq_drive),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
      .addr(dram_addr));

   assign dram_dq = dq_drive ? dq_out : {DATA_W{1'bz}};
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
   parameter int MUX_W = 9,
   parameter int T_RC  = 22,
   parameter int T_PC  = 7,
   parameter int T_CAC = 3,
   parameter int T_RP  = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ras_n,
   input logic             cas_n,
   input logic             we_n,
   input logic             oe_n,
   input logic [MUX_W-1:0] addr,
   input logic             dq_drive,
   input logic             req_ready,
   input logic             rd_valid
);
   logic [7:0] ras_gap, cas_gap, pre_gap;
   logic       ras_prev, cas_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_gap  <= 8'hFF;
         cas_gap  <= 8'hFF;
         pre_gap  <= 8'hFF;
         ras_prev <= 1'b1;
         cas_prev <= 1'b1;
      end else begin
         ras_prev <= ras_n;
         cas_prev <= cas_n;
         if (ras_prev && !ras_n)     ras_gap <= 8'd1;
         else if (ras_gap != 8'hFF)  ras_gap <= ras_gap + 8'd1;
         if (cas_prev && !cas_n)     cas_gap <= 8'd1;
         else if (cas_gap != 8'hFF)  cas_gap <= cas_gap + 8'd1;
         if (!ras_prev && ras_n)     pre_gap <= 8'd1;
         else if (pre_gap != 8'hFF)  pre_gap <= pre_gap + 8'd1;
      end
   end

   // R7
   row_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_prev && !ras_n) |-> (int'(ras_gap) >= T_RC));

   // R8
   page_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_prev && !cas_n) |-> (int'(cas_gap) >= T_PC));

   // R8
   cas_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_prev && cas_n) |-> (int'(cas_gap) >= T_CAC));

   // R6
   precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_prev && !ras_n) |-> (int'(pre_gap) >= T_RP));

   // R2
   row_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> $stable(addr));

   // R2
   col_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> $stable(addr));

   // R3
   early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !we_n) |-> $past(!we_n));

   // R3
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n));

   // R4
   read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !dq_drive);

   // R5
   cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   // R13
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> cas_n);

   // R4
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
   .MUX_W(MUX_W), .T_RC(T_RC), .T_PC(T_PC), .T_CAC(T_CAC), .T_RP(T_RP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
   .we_n(dram_we_n), .oe_n(dram_oe_n), .addr(dram_addr), .dq_drive(dq_drive),
   .req_ready(req_ready), .rd_valid(rd_valid));

// File: tb/fpm_dram_ctrl_tb.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb;
   localparam int T_RAC = 12, T_RC = 22, T_CAC = 3, T_PC = 7, T_RP = 10;
   localparam int T_RCD = T_RAC - T_CAC;
   localparam int REF_P = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_hold = 1'b0;
   logic [17:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid;
   logic [7:0]  rd_data;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
   logic [8:0]  dram_addr;
   wire  [7:0]  dram_dq;

   int n_chk = 0, n_fail = 0, cyc = 0;

   fpm_dram_ctrl #(.REF_PERIOD(REF_P)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_hold(req_hold), .rd_valid(rd_valid), .rd_data(rd_data),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq(dram_dq));

   always #2.5 clk = ~clk;
   always @(negedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] init_val(input int k);
      return k[7:0] ^ k[16:9] ^ 8'h5A;
   endfunction

   // behavioural device
   logic [8:0] m_row = '0, m_col = '0;
   logic [7:0] m_rd = '0;
   logic [7:0] mem [int];
   assign dram_dq = (!dram_ras_n && !dram_cas_n && !dram_oe_n) ? m_rd : 8'bz;

   // bench-side observation
   int  last_ras_fall = -1, last_ras_rise = -1, last_cas_fall = -1, we_fall = -1;
   int  ras_falls = 0, ref_cnt = 0, prev_ref_row = -1;
   bit  cas_in_row = 1'b0, r13_bad = 1'b0;
   logic [8:0] lat_row = '0;

   always @(negedge dram_ras_n) begin
      m_row = dram_addr;
      lat_row = dram_addr;
      if (last_ras_fall >= 0) chk(cyc - last_ras_fall >= T_RC, "R7 row cycle", cyc - last_ras_fall, T_RC);
      if (last_ras_rise >= 0) chk(cyc - last_ras_rise >= T_RP, "R6 precharge", cyc - last_ras_rise, T_RP);
      last_ras_fall = cyc;
      ras_falls++;
      cas_in_row = 1'b0;
   end

   always @(posedge dram_ras_n) begin
      if (last_ras_fall >= 0) begin
         last_ras_rise = cyc;
         if (!cas_in_row) begin
            ref_cnt++;
            chk(cyc - last_ras_fall >= T_RAC, "R10 refresh width", cyc - last_ras_fall, T_RAC);
            if (prev_ref_row >= 0)
               chk(int'(lat_row) == ((prev_ref_row + 1) % 512), "R10 refresh order",
                   int'(lat_row), (prev_ref_row + 1) % 512);
            prev_ref_row = int'(lat_row);
         end
      end
   end

   always @(negedge dram_we_n) we_fall = cyc;

   always @(negedge dram_cas_n) begin
      m_col = dram_addr;
      if (!cas_in_row)
         chk(cyc - last_ras_fall >= T_RCD, "R9 ras to cas", cyc - last_ras_fall, T_RCD);
      if (last_cas_fall >= 0)
         chk(cyc - last_cas_fall >= T_PC, "R8 page cycle", cyc - last_cas_fall, T_PC);
      cas_in_row = 1'b1;
      last_cas_fall = cyc;
      if (!dram_we_n) begin
         chk(dram_oe_n === 1'b1 && we_fall < cyc, "R3 early write", we_fall, cyc - 1);
         mem[{m_row, m_col}] = dram_dq;
      end else begin
         m_rd = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : init_val({m_row, m_col});
      end
   end

   always @(posedge dram_cas_n)
      if (last_cas_fall >= 0)
         chk(cyc - last_cas_fall >= T_CAC, "R8 cas width", cyc - last_cas_fall, T_CAC);

   // expected read data
   logic [7:0] exp_mem [int];
   logic [7:0] exp_q [$];

   always @(negedge clk) begin
      if (rst_n && req_ready && !dram_cas_n) r13_bad = 1'b1;
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R4 unexpected rd_valid", 1, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rd_data == e, "R4 read data", int'(rd_data), int'(e));
         end
      end
   end

   task automatic do_req(input bit wr, input logic [17:0] a, input logic [7:0] d, input bit hold);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_hold = hold;
      @(negedge clk);
      req_valid = 1'b0;
      if (wr) exp_mem[int'(a)] = d;
      else exp_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_val(int'(a)));
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      int rf;
      void'($urandom(32'd4242));
      settle(3);
      // R1 reset state
      chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'b1111, "R1 strobes",
          int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);
      chk(req_ready == 1'b1 && rd_valid == 1'b0, "R1 ready/valid", int'({req_ready, rd_valid}), 2);
      chk(dram_dq === 8'bz, "R1 bus released", int'(dram_dq), 0);
      rst_n = 1'b1;
      settle(2);

      // R2 + R12: write with hint clear
      rf = ras_falls;
      do_req(1'b1, 18'h12345, 8'hA5, 1'b0);
      settle(T_RCD + T_CAC + 6);
      chk(m_row == 9'h091 && m_col == 9'h145, "R2 address split",
          int'({m_row, m_col}), int'(18'h12345));
      chk(dram_ras_n == 1'b1, "R12 row closed", int'(dram_ras_n), 1);

      // R4 + R5: read back with hint set, then same-row hits
      do_req(1'b0, 18'h12345, 8'h00, 1'b1);
      settle(T_RCD + T_CAC + 6);
      chk(dram_ras_n == 1'b0, "R5 row held open", int'(dram_ras_n), 0);
      rf = ras_falls;
      do_req(1'b1, 18'h12346, 8'h3C, 1'b1);
      do_req(1'b0, 18'h12346, 8'h00, 1'b1);
      do_req(1'b0, 18'h12345, 8'h00, 1'b1);
      settle(T_PC + 6);
      chk(ras_falls == rf, "R5 page hits without row strobe", ras_falls - rf, 0);

      // R6: row miss reopens
      do_req(1'b0, 18'h2A001, 8'h00, 1'b0);
      settle(T_RP + T_RC + 6);
      chk(ras_falls == rf + 1, "R6 row miss reopen", ras_falls - rf, 1);

      // R11: refresh pre-empts held-open row
      do_req(1'b1, 18'h00777, 8'h99, 1'b1);
      settle(T_RCD + T_CAC + 6);
      rf = ref_cnt;
      chk(dram_ras_n == 1'b0, "R11 row open before refresh", int'(dram_ras_n), 0);
      settle(REF_P + 60);
      chk(ref_cnt > rf, "R11 refresh served", ref_cnt - rf, 1);
      chk(dram_ras_n == 1'b1, "R11 open row closed", int'(dram_ras_n), 1);
      do_req(1'b0, 18'h00777, 8'h00, 1'b0);

      // constrained random traffic
      for (int i = 0; i < 300; i++) begin
         logic [17:0] a;
         a = {9'($urandom_range(0, 3) * 37), 9'($urandom_range(0, 15))};
         do_req(1'($urandom_range(0, 1)), a, 8'($urandom), 1'($urandom_range(0, 1)));
      end
      settle(3 * T_RC);

      chk(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
      chk(ref_cnt >= 5, "R10 refresh count", ref_cnt, 5);
      chk(!r13_bad, "R13 ready only with column strobe high", int'(r13_bad), 0);
      finish_run();
   end
endmodule